// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Frame Sequencer

This block drives a six-channel analog-to-digital converter that samples all of its inputs at the same instant and hands the results over a shared 16-bit parallel bus. On a sample request, and only when the converter reports itself idle, it pulses a conversion start. It then waits for the converter's busy line to rise and fall again, and finally reads the six held words one after another. During the readout a chip select is held low and a read strobe is pulsed low once per word.

Only three of the six words are of interest to the control loop: the line voltage, the DC bus voltage and the inductor current. These sit on the first three channels. They are moved into output registers together and announced by a single-cycle valid pulse. The last three words are read to complete the frame and then dropped. A timeout returns the sequencer to rest if the converter never reports completion. This keeps a stuck converter from holding the control loop forever.

Top module: `adc_frame_seq`

## Requirements
- R1: After reset, conv_start is 0, cs_n and rd_n are 1, res_valid is 0 and all three result outputs are 0.
- R2: A sample_req seen while the sequencer is at rest and busy is low raises conv_start for exactly 2 clock cycles.
- R3: A sample_req is ignored while busy is high at rest and while a frame is in progress; it is not remembered, and each accepted request gives exactly one conv_start pulse.
- R4: After busy falls, exactly six low pulses appear on rd_n, each with cs_n low; cs_n is high outside the readout.
- R5: Each rd_n low pulse lasts exactly 3 cycles, and consecutive pulses within a frame are separated by exactly 2 high cycles.
- R6: A word is latched on the clock edge at which rd_n returns high. Words are taken in channel order 1 to 6; channel 1 goes to line_v, channel 2 to bus_v and channel 3 to ind_i, and channels 4 to 6 are discarded.
- R7: res_valid is high for exactly one cycle, 28 clock edges after the edge that first samples busy low. The three result outputs change only at that edge.
- R8: If busy has not completed a rise and fall within 500 cycles (5 us at 100 MHz) of the end of the start pulse, the sequencer returns to rest without any read strobe or valid pulse. A busy that falls before that limit still yields a full frame.
- R9: With conversions lasting up to 300 cycles, the time from an accepted request to res_valid stays within 400 cycles (4 us).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_req | input | 1 | Request for one acquisition frame |
| busy | input | 1 | Converter busy flag, high during conversion |
| adc_data | input | 16 | Parallel data bus from the converter |
| conv_start | output | 1 | Conversion start pulse to the converter |
| cs_n | output | 1 | Chip select, active low during readout |
| rd_n | output | 1 | Read strobe, active low |
| line_v | output | 16 | Channel 1 result (line voltage) |
| bus_v | output | 16 | Channel 2 result (DC bus voltage) |
| ind_i | output | 16 | Channel 3 result (inductor current) |
| res_valid | output | 1 | One-cycle pulse marking fresh results |

## Verification
The start pulse appears one edge after the request is sampled. The valid pulse and new results follow 28 edges after the edge that first sees busy low: six words of 3 low and 2 high cycles each, minus the trailing gap. The bench models the converter and records the cycle in which it drops busy. It expects res_valid exactly 29 falling-edge samples later, so a shifted capture or a miscounted strobe shows up as a latency error. Strobe widths, gaps and start-pulse lengths are counted sample by sample at the falling edge, away from the edge where the design updates. The watchdog boundary is probed with busy released 440 cycles after the request, which must still give a frame, and with busy held 520 cycles, which must give none.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_WRISE,
        ST_WFALL,
        ST_RLO,
        ST_RHI
    } seq_state_e;

    localparam int unsigned USED_CH = 3;
    localparam int unsigned SEL_W   = 8;

    function automatic int unsigned ns_to_cycles(input int unsigned mhz, input int unsigned ns);
        return (mhz * ns) / 1000;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/adc_seq_wdog.sv
module adc_seq_wdog #(
    parameter int unsigned LIMIT = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expire = run && (cnt == LAST);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned NUM_CH    = 6,
    parameter int unsigned START_CYC = 2,
    parameter int unsigned RD_LOW    = 3,
    parameter int unsigned RD_HIGH   = 2,
    parameter int unsigned IDX_W     = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_req,
    input  logic             busy,
    input  logic             wdog_expire,
    output logic             conv_start,
    output logic             cs_n,
    output logic             rd_n,
    output logic             wait_act,
    output logic             cap_en,
    output logic             frame_done,
    output logic [IDX_W-1:0] cap_idx
);
    localparam int unsigned PH_W = $clog2(max3(START_CYC, RD_LOW, RD_HIGH) + 1);
    localparam logic [PH_W-1:0] START_LAST = PH_W'(START_CYC - 1);
    localparam logic [PH_W-1:0] LOW_LAST   = PH_W'(RD_LOW - 1);
    localparam logic [PH_W-1:0] HIGH_LAST  = PH_W'(RD_HIGH - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(NUM_CH - 1);

    seq_state_e      state;
    logic [PH_W-1:0] ph;

    assign wait_act   = (state == ST_WRISE) || (state == ST_WFALL);
    assign cap_en     = (state == ST_RLO) && (ph == LOW_LAST);
    assign frame_done = cap_en && (cap_idx == IDX_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            ph         <= '0;
            cap_idx    <= '0;
            conv_start <= 1'b0;
            cs_n       <= 1'b1;
            rd_n       <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (sample_req && !busy) begin
                        state      <= ST_START;
                        conv_start <= 1'b1;
                        ph         <= '0;
                    end
                end
                ST_START: begin
                    if (ph == START_LAST) begin
                        conv_start <= 1'b0;
                        state      <= ST_WRISE;
                        ph         <= '0;
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                ST_WRISE: begin
                    if (wdog_expire) begin
                        state <= ST_IDLE;
                    end else if (busy) begin
                        state <= ST_WFALL;
                    end
                end
                ST_WFALL: begin
                    if (wdog_expire) begin
                        state <= ST_IDLE;
                    end else if (!busy) begin
                        state   <= ST_RLO;
                        cs_n    <= 1'b0;
                        rd_n    <= 1'b0;
                        ph      <= '0;
                        cap_idx <= '0;
                    end
                end
                ST_RLO: begin
                    if (ph == LOW_LAST) begin
                        rd_n <= 1'b1;
                        ph   <= '0;
                        if (cap_idx == IDX_LAST) begin
                            cs_n  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_RHI;
                        end
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                ST_RHI: begin
                    if (ph == HIGH_LAST) begin
                        rd_n    <= 1'b0;
                        ph      <= '0;
                        cap_idx <= cap_idx + 1'b1;
                        state   <= ST_RLO;
                    end else begin
                        ph <= ph + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture
    import adc_seq_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned IDX_W   = 3,
    parameter logic [USED_CH*SEL_W-1:0] SEL_MAP = '0
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             cap_en,
    input  logic                             frame_done,
    input  logic [IDX_W-1:0]                 cap_idx,
    input  logic [DATA_W-1:0]                din,
    output logic [USED_CH-1:0][DATA_W-1:0]   res,
    output logic                             res_valid
);
    for (genvar k = 0; k < USED_CH; k++) begin : g_slot
        localparam int unsigned SEL = int'(SEL_MAP[k*SEL_W +: SEL_W]);
        logic [DATA_W-1:0] shadow;
        logic              hit;

        assign hit = (int'(cap_idx) == SEL);

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow <= '0;
                res[k] <= '0;
            end else begin
                if (cap_en && hit) begin
                    shadow <= din;
                end
                if (frame_done) begin
                    res[k] <= hit ? din : shadow;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
        end else begin
            res_valid <= frame_done;
        end
    end
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
    import adc_seq_pkg::*;
#(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned NUM_CH      = 6,
    parameter int unsigned CLK_MHZ     = 100,
    parameter int unsigned BUSY_TMO_NS = 5000,
    parameter int unsigned START_CYC   = 2,
    parameter int unsigned RD_LOW      = 3,
    parameter int unsigned RD_HIGH     = 2,
    parameter int unsigned LINE_CH     = 0,
    parameter int unsigned BUS_CH      = 1,
    parameter int unsigned IND_CH      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_req,
    input  logic              busy,
    input  logic [DATA_W-1:0] adc_data,
    output logic              conv_start,
    output logic              cs_n,
    output logic              rd_n,
    output logic [DATA_W-1:0] line_v,
    output logic [DATA_W-1:0] bus_v,
    output logic [DATA_W-1:0] ind_i,
    output logic              res_valid
);
    localparam int unsigned IDX_W   = $clog2(NUM_CH);
    localparam int unsigned TMO_CYC = ns_to_cycles(CLK_MHZ, BUSY_TMO_NS);
    localparam logic [USED_CH*SEL_W-1:0] SEL_MAP =
        {SEL_W'(IND_CH), SEL_W'(BUS_CH), SEL_W'(LINE_CH)};

    logic                            wait_act;
    logic                            wdog_expire;
    logic                            cap_en;
    logic                            frame_done;
    logic [IDX_W-1:0]                cap_idx;
    logic [USED_CH-1:0][DATA_W-1:0]  res;

    adc_seq_ctrl #(
        .NUM_CH   (NUM_CH),
        .START_CYC(START_CYC),
        .RD_LOW   (RD_LOW),
        .RD_HIGH  (RD_HIGH),
        .IDX_W    (IDX_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sample_req (sample_req),
        .busy       (busy),
        .wdog_expire(wdog_expire),
        .conv_start (conv_start),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .wait_act   (wait_act),
        .cap_en     (cap_en),
        .frame_done (frame_done),
        .cap_idx    (cap_idx)
    );

    adc_seq_wdog #(
        .LIMIT(TMO_CYC)
    ) u_wdog (
        .clk   (clk),
        .rst   (rst),
        .run   (wait_act),
        .expire(wdog_expire)
    );

    adc_seq_capture #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .SEL_MAP(SEL_MAP)
    ) u_cap (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (cap_en),
        .frame_done(frame_done),
        .cap_idx   (cap_idx),
        .din       (adc_data),
        .res       (res),
        .res_valid (res_valid)
    );

    assign line_v = res[0];
    assign bus_v  = res[1];
    assign ind_i  = res[2];
endmodule

// File: rtl/adc_frame_seq_chk.sv
module adc_frame_seq_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned RD_LOW = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              conv_start,
    input logic              cs_n,
    input logic              rd_n,
    input logic [DATA_W-1:0] line_v,
    input logic [DATA_W-1:0] bus_v,
    input logic [DATA_W-1:0] ind_i,
    input logic              res_valid
);
    logic [7:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || rd_n) begin
            low_cnt <= '0;
        end else if (low_cnt != 8'hFF) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    AST_RD_UNDER_CS: assert property (@(posedge clk) disable iff (rst) !rd_n |-> !cs_n); // R4
    AST_RD_LOW_WIDTH: assert property (@(posedge clk) disable iff (rst) $rose(rd_n) |-> (low_cnt >= 8'(RD_LOW))); // R5
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) res_valid |=> !res_valid); // R7
    AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> ($stable(line_v) && $stable(bus_v) && $stable(ind_i))); // R7
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst) $rose(conv_start) |-> !$past(busy)); // R3
    AST_START_OUTSIDE_READ: assert property (@(posedge clk) disable iff (rst) conv_start |-> (cs_n && rd_n)); // R2
endmodule

bind adc_frame_seq adc_frame_seq_chk #(
    .DATA_W(DATA_W),
    .RD_LOW(RD_LOW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .conv_start(conv_start),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .line_v    (line_v),
    .bus_v     (bus_v),
    .ind_i     (ind_i),
    .res_valid (res_valid)
);

// File: tb/adc_frame_seq_test.sv
`timescale 1ns/1ps
module adc_frame_seq_test;
    localparam int RD_LOW_T  = 3;
    localparam int RD_HIGH_T = 2;
    localparam int VALID_LAG = 29;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_req = 1'b0;
    logic        busy = 1'b0;
    logic [15:0] adc_data = '0;
    logic        conv_start, cs_n, rd_n, res_valid;
    logic [15:0] line_v, bus_v, ind_i;

    always #5 clk = ~clk;

    adc_frame_seq uut (
        .clk(clk), .rst(rst), .sample_req(sample_req), .busy(busy),
        .adc_data(adc_data), .conv_start(conv_start), .cs_n(cs_n), .rd_n(rd_n),
        .line_v(line_v), .bus_v(bus_v), .ind_i(ind_i), .res_valid(res_valid)
    );

    int n_chk = 0;
    int n_bad = 0;

    function automatic void chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endfunction

    // converter model and port monitor, all at the falling edge
    logic [15:0] vals [6];
    int  conv_len = 20;
    bit  stuck = 0;
    bit  hold_high = 0;
    bit  running = 0;
    int  cnt = 0;
    int  rd_idx = 0;
    int  cyc = 0;
    int  fall_cyc = 0;
    int  valid_cyc = 0;
    int  valid_cnt = 0;
    int  conv_rises = 0;
    int  rd_falls = 0;
    int  rd_in_frame = 0;
    int  low_len = 0;
    int  high_len = 0;
    int  cs_len = 0;
    bit  prev_rd = 1, prev_cs = 0, prev_valid = 0;

    always @(negedge clk) begin
        cyc++;
        if (hold_high) begin
            busy = 1'b1;
        end else if (conv_start && !busy && !running) begin
            busy = 1'b1; running = 1; cnt = conv_len;
        end else if (running) begin
            if (!stuck) begin
                cnt--;
                if (cnt <= 0) begin
                    busy = 1'b0; running = 0; fall_cyc = cyc; rd_idx = 0;
                end
            end
        end else begin
            busy = 1'b0;
        end

        if (!rst) begin
            if (conv_start) cs_len++;
            if (conv_start && !prev_cs) conv_rises++;
            if (!conv_start && prev_cs) begin
                chk(cs_len == 2, "R2 start width", cs_len, 2);
                cs_len = 0;
            end
            if (!rd_n && prev_rd) begin
                chk(!cs_n, "R4 cs_n low during read", int'(cs_n), 0);
                if (rd_in_frame > 0) chk(high_len == RD_HIGH_T, "R5 gap width", high_len, RD_HIGH_T);
                rd_falls++; rd_in_frame++; low_len = 0;
            end
            if (!rd_n) low_len++;
            if (rd_n) high_len++;
            if (rd_n && !prev_rd) begin
                chk(low_len == RD_LOW_T, "R5 strobe width", low_len, RD_LOW_T);
                rd_idx++; high_len = 1;
            end
            if (prev_valid) chk(!res_valid, "R7 valid one cycle", int'(res_valid), 0);
            if (res_valid && !prev_valid) begin
                valid_cnt++; valid_cyc = cyc;
                chk(cyc - fall_cyc == VALID_LAG, "R7 valid lag", cyc - fall_cyc, VALID_LAG);
                chk(rd_in_frame == 6, "R4 reads per frame", rd_in_frame, 6);
                chk(line_v == vals[0], "R6 line_v", int'(line_v), int'(vals[0]));
                chk(bus_v  == vals[1], "R6 bus_v",  int'(bus_v),  int'(vals[1]));
                chk(ind_i  == vals[2], "R6 ind_i",  int'(ind_i),  int'(vals[2]));
                rd_in_frame = 0;
            end
            if (cs_n && !rd_n) chk(0, "R4 strobe outside select", 1, 0);
        end
        adc_data = vals[(rd_idx > 5) ? 5 : rd_idx];
        prev_rd = rd_n; prev_cs = conv_start; prev_valid = res_valid;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse_req();
        sample_req = 1'b1;
        tick(1);
        sample_req = 1'b0;
    endtask

    task automatic run_frame(input int len, input logic [15:0] a, b, c, d, e, f, input bit poke);
        int r0, v0, req_cyc, extra;
        vals[0] = a; vals[1] = b; vals[2] = c; vals[3] = d; vals[4] = e; vals[5] = f;
        conv_len = len;
        r0 = conv_rises; v0 = valid_cnt; req_cyc = cyc;
        pulse_req();
        if (poke) begin
            extra = 5 + int'($urandom_range(0, len + 20));
            tick(extra);
            pulse_req(); // R3 request during frame
        end
        for (int i = 0; i < 1200 && valid_cnt == v0; i++) tick(1);
        chk(valid_cnt == v0 + 1, "R6 frame completed", valid_cnt - v0, 1);
        chk(valid_cyc - req_cyc <= 400, "R9 frame budget", valid_cyc - req_cyc, 400);
        tick(5);
        chk(conv_rises == r0 + 1, "R3 one start per frame", conv_rises - r0, 1);
    endtask

    initial begin
        int r0, v0, f0;
        void'($urandom(32'd2718));
        for (int k = 0; k < 6; k++) vals[k] = '0;
        tick(4);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk(conv_start == 0 && cs_n == 1 && rd_n == 1 && res_valid == 0, "R1 control idle",
            int'({conv_start, cs_n, rd_n, res_valid}), 6);
        chk(line_v == 0 && bus_v == 0 && ind_i == 0, "R1 results cleared",
            int'(line_v | bus_v | ind_i), 0);

        // directed patterns
        run_frame(20, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEAD, 16'hBEEF, 16'hCAFE, 0);
        run_frame(300, 16'hFFFF, 16'h0000, 16'h8000, 16'h0001, 16'h7FFF, 16'hAAAA, 1);
        run_frame(40, 16'h0000, 16'hFFFF, 16'h0001, 16'h1111, 16'h2222, 16'h3333, 1);

        // random frames
        for (int n = 0; n < 10; n++) begin
            run_frame(int'($urandom_range(20, 300)),
                      16'($urandom), 16'($urandom), 16'($urandom),
                      16'($urandom), 16'($urandom), 16'($urandom), 1);
        end

        // R3: request ignored while busy is high at rest, and not remembered
        hold_high = 1; tick(2);
        r0 = conv_rises;
        pulse_req();
        tick(10);
        chk(conv_rises == r0, "R3 busy-high request ignored", conv_rises - r0, 0);
        hold_high = 0; tick(20);
        chk(conv_rises == r0, "R3 request not remembered", conv_rises - r0, 0);

        // R8: busy released before the limit still gives a frame
        vals[0] = 16'h0A0A; vals[1] = 16'h0B0B; vals[2] = 16'h0C0C;
        conv_len = 1; stuck = 1;
        v0 = valid_cnt;
        pulse_req();
        tick(440);
        stuck = 0;
        tick(60);
        chk(valid_cnt == v0 + 1, "R8 late busy inside limit", valid_cnt - v0, 1);

        // R8: busy stuck past the limit gives no frame
        conv_len = 1; stuck = 1;
        v0 = valid_cnt; f0 = rd_falls;
        pulse_req();
        tick(520);
        stuck = 0;
        tick(60);
        chk(rd_falls == f0, "R8 no strobe after timeout", rd_falls - f0, 0);
        chk(valid_cnt == v0, "R8 no valid after timeout", valid_cnt - v0, 0);
        rd_in_frame = 0;

        // recovery
        run_frame(60, 16'h4321, 16'h8765, 16'hCBA9, 16'h0F0F, 16'hF0F0, 16'h5555, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule